// File: doc/BRIEF.md
# Slow-Clock Synchronous Peripheral Cycle Controller

This block is the processor-side timing engine for older, slow peripherals that cannot answer a fast asynchronous handshake. From the processor clock it makes a free-running slow enable clock, which sets the timing for those devices. It then watches each bus cycle for an active-low reply from a device saying "I am a slow synchronous peripheral".

When that reply comes while the address strobe is asserted, the block holds the cycle open. It waits for the next falling edge of the enable clock and marks the moment of lock by driving its active-low valid-address output. It ends the transfer with a one-clock completion pulse at the end of the enable-high phase that follows. The valid-address output stays asserted until the strobe is withdrawn. A strobe withdrawn before lock aborts the cycle with no marking. Data steering and handshake-terminated cycles belong to other logic.

Top module: `sync_periph_cycle`

## Requirements
- R1: While `rst_n` is low, `eclk` is 0, `vma_n` is 1 and `cyc_done` is 0.
- R2: `eclk` repeats every LOW_CLKS+HIGH_CLKS clocks (defaults 6 and 4). The first LOW_CLKS clocks after reset release are low and the next HIGH_CLKS are high. It runs independently of any bus activity.
- R3: A cycle with `as_n`=0 and `vpa_n`=1 never asserts `vma_n` and never produces `cyc_done`.
- R4: When `as_n`=0 and `vpa_n`=0 are sampled at a clock edge, `vma_n` goes to 0 on the first later clock edge at which `eclk` falls.
- R5: After lock, `cyc_done` is 1 for exactly one clock. That clock is the last clock of the enable-high phase following the lock.
- R6: After `cyc_done`, `vma_n` stays 0 until `as_n`=1 is sampled. It returns to 1 at that same edge.
- R7: If `as_n`=1 is sampled after the request but before lock, the block goes idle with neither `vma_n` asserted nor `cyc_done` produced.
- R8: Once the request has been sampled, later changes of `vpa_n` have no effect on the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| vpa_n | input | 1 | Slow-peripheral reply, active low |
| eclk | output | 1 | Free-running slow enable clock |
| vma_n | output | 1 | Valid-address marker after lock, active low |
| cyc_done | output | 1 | One-clock pulse ending the synchronous transfer |

## Verification
The assertions assume that `as_n` stays low from the request until `cyc_done` has been seen, so the block never has to release a locked cycle early. They also assume that both inputs are synchronous to `clk`. The stimulus drives every input on the falling clock edge. Each synchronous request holds the strobe until the completion pulse has passed, and it is aborted only in the deliberate pre-lock test. The request start is swept across all ten enable-clock phases so that every wait length is exercised.

// File: rtl/eclk_sync_pkg.sv
package eclk_sync_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SYNC = 2'd2,
      ST_HOLD = 2'd3
   } cyc_state_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/eclk_gen.sv
module eclk_gen #(
   parameter int unsigned LOW_CLKS  = 6,
   parameter int unsigned HIGH_CLKS = 4,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   output logic eclk_o,
   output logic last_o
);
   import eclk_sync_pkg::*;

   localparam int unsigned PERIOD = LOW_CLKS + HIGH_CLKS;
   localparam int unsigned CW     = cnt_width(PERIOD);
   localparam logic [CW-1:0] LAST_V = CW'(PERIOD - 1);
   localparam logic [CW-1:0] HIGH_V = CW'(LOW_CLKS);

   initial begin : p_param_chk
      assert (LOW_CLKS >= 1) else $fatal(1, "LOW_CLKS must be at least 1");
      assert (HIGH_CLKS >= 1) else $fatal(1, "HIGH_CLKS must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;

   assign last_o = (cnt_q == LAST_V);
   assign cnt_nx = last_o ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nx;
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic e_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) e_q <= 1'b0;
            else        e_q <= (cnt_nx >= HIGH_V);
         end
         assign eclk_o = e_q;
      end else begin : g_dec_out
         assign eclk_o = (cnt_q >= HIGH_V);
      end
   endgenerate

   // R2: the enable clock rises only after the full low phase
   a_r2_rise_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eclk_o) |-> (cnt_q == HIGH_V));
   // R2: the enable clock falls only at the period wrap
   a_r2_fall_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eclk_o) |-> (cnt_q == '0));

endmodule

// File: rtl/vpa_sync_fsm.sv
module vpa_sync_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic as_n,
   input  logic vpa_n,
   input  logic e_last,
   output logic vma_n,
   output logic done
);
   import eclk_sync_pkg::*;

   cyc_state_t st_q, st_nx;
   logic       vma_q;

   always_comb begin
      st_nx = st_q;
      case (st_q)
         ST_IDLE: if (!as_n && !vpa_n) st_nx = ST_WAIT;
         ST_WAIT: begin
            if (as_n)        st_nx = ST_IDLE;
            else if (e_last) st_nx = ST_SYNC;
         end
         ST_SYNC: if (e_last) st_nx = ST_HOLD;
         ST_HOLD: if (as_n)   st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         vma_q <= 1'b0;
      end else begin
         st_q  <= st_nx;
         vma_q <= (st_nx == ST_SYNC) || (st_nx == ST_HOLD);
      end
   end

   assign vma_n = ~vma_q;
   assign done  = (st_q == ST_SYNC) && e_last;

   // R7: withdrawal of the strobe before lock never marks the cycle
   a_r7_abort_no_vma: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && as_n) |=> vma_n);
   // R6: the marker is released only after the strobe was seen high
   a_r6_release_on_as: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vma_n) |-> $past(as_n));
   // R5: completion is a single-clock pulse
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/sync_periph_cycle.sv
module sync_periph_cycle #(
   parameter int unsigned LOW_CLKS  = 6,
   parameter int unsigned HIGH_CLKS = 4,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_n,
   input  logic vpa_n,
   output logic eclk,
   output logic vma_n,
   output logic cyc_done
);
   logic e_last;

   eclk_gen #(
      .LOW_CLKS (LOW_CLKS),
      .HIGH_CLKS(HIGH_CLKS),
      .REG_OUT  (REG_OUT)
   ) u_egen (
      .clk   (clk),
      .rst_n (rst_n),
      .eclk_o(eclk),
      .last_o(e_last)
   );

   vpa_sync_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .as_n  (as_n),
      .vpa_n (vpa_n),
      .e_last(e_last),
      .vma_n (vma_n),
      .done  (cyc_done)
   );

   // R4: the marker is asserted only together with a falling enable clock
   a_r4_lock_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vma_n) |-> $fell(eclk));
   // R5: completion lies inside a locked, enable-high clock
   a_r5_done_in_high: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> (eclk && !vma_n));
   // R5: completion is the last clock of the high phase
   a_r5_done_last_high: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !eclk);

endmodule

// File: tb/sync_periph_cycle_test.sv
module sync_periph_cycle_test;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, as_n, vpa_n;
   logic eclk, vma_n, cyc_done;

   sync_periph_cycle uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .as_n    (as_n),
      .vpa_n   (vpa_n),
      .eclk    (eclk),
      .vma_n   (vma_n),
      .cyc_done(cyc_done)
   );

   int    errors = 0;
   int    checks = 0;
   int    done_cnt = 0;
   int    vma_low_cnt = 0;
   int    cyc = 0;
   bit    finished = 0;
   string tag = "R2";

   // behavioural reference: phase of the enable clock and cycle progress
   int ph;    // clocks since the last enable-clock fall
   int prog;  // 0 none, 1 requested, 2 locked, 3 completed

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph = 0;
         prog = 0;
      end else begin
         if (prog == 0) begin
            if (!as_n && !vpa_n) prog = 1;
         end else if (prog == 1) begin
            if (as_n) prog = 0;
            else if (ph == 9) prog = 2;
         end else if (prog == 2) begin
            if (ph == 9) prog = 3;
         end else begin
            if (as_n) prog = 0;
         end
         ph = (ph + 1) % 10;
      end
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2", int'(eclk), int'(ph >= 6), "eclk");
         chk(tag, int'(vma_n), int'(!(prog == 2 || prog == 3)), "vma_n");
         chk("R5", int'(cyc_done), int'(prog == 2 && ph == 9), "cyc_done");
         if (cyc_done) done_cnt++;
         if (!vma_n) vma_low_cnt++;
         cyc++;
         if (cyc > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements actual=%0d expected<=5000", cyc);
            finish_run();
         end
      end
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int d0;
      int v0;
      rst_n = 1'b0;
      as_n  = 1'b1;
      vpa_n = 1'b1;
      wait_clks(3);
      // R1: reset state
      chk("R1", int'(eclk), 0, "eclk in reset");
      chk("R1", int'(vma_n), 1, "vma_n in reset");
      chk("R1", int'(cyc_done), 0, "cyc_done in reset");
      rst_n = 1'b1;

      // R2: free-running enable clock with no bus activity
      tag = "R2";
      wait_clks(25);

      // R3: strobe cycle without slow-peripheral reply
      tag = "R3";
      d0 = done_cnt;
      v0 = vma_low_cnt;
      as_n = 1'b0;
      wait_clks(30);
      as_n = 1'b1;
      wait_clks(3);
      chk("R3", vma_low_cnt - v0, 0, "vma_n asserted without reply");
      chk("R3", done_cnt - d0, 0, "done without reply");

      // R4, R5, R6: synchronous cycles started at every enable phase
      for (int k = 0; k < 10; k++) begin
         wait_clks(k + 1);
         d0 = done_cnt;
         tag = "R4";
         as_n = 1'b0;
         vpa_n = 1'b0;
         for (int i = 0; i < 40 && done_cnt == d0; i++) @(negedge clk);
         wait_clks(1);
         vpa_n = 1'b1;
         tag = "R6";
         wait_clks(3);
         chk("R6", int'(vma_n), 0, "vma_n held while strobe low");
         as_n = 1'b1;
         wait_clks(3);
         chk("R5", done_cnt - d0, 1, "done pulses per cycle");
         chk("R6", int'(vma_n), 1, "vma_n after strobe release");
      end

      // R7: abort before lock
      tag = "R7";
      d0 = done_cnt;
      v0 = vma_low_cnt;
      as_n = 1'b0;
      vpa_n = 1'b0;
      wait_clks(1);
      as_n = 1'b1;
      vpa_n = 1'b1;
      wait_clks(20);
      chk("R7", vma_low_cnt - v0, 0, "vma_n on aborted cycle");
      chk("R7", done_cnt - d0, 0, "done on aborted cycle");

      // R8: reply withdrawn after sampling does not cancel the cycle
      tag = "R8";
      d0 = done_cnt;
      as_n = 1'b0;
      vpa_n = 1'b0;
      wait_clks(1);
      vpa_n = 1'b1;
      wait_clks(25);
      chk("R8", done_cnt - d0, 1, "cycle completes after reply withdrawn");
      as_n = 1'b1;
      wait_clks(5);
      chk("R8", int'(vma_n), 1, "vma_n idle at end");

      finish_run();
   end

endmodule